// File: doc/BRIEF.md
# Scrambling 4b/5b NRZI Line Coder

This block is the last digital stage of a 25.6 Mbps cell-based transmitter. An upstream framer hands it one nibble at a time, marked as scrambled cell data, as a command symbol, or as the start-of-cell command that reseeds the scrambler. Data nibbles are XORed with four keystream bits from a pseudo-random generator. Every nibble then becomes a 5-bit code group. The groups are shifted out one bit per line-clock cycle, and the bit stream is NRZI coded onto a single line output.

A command symbol goes out as an escape group followed by the unscrambled code group of its nibble. The escape group is a code that no data nibble can produce, so a receiver cannot mistake a command for data. The reseeding command goes out as two escape groups and returns the generator to its seed. The framer paces itself with a ready signal. That signal rises while the last bit of the current group is still on the line, so nibbles fed back to back give an unbroken bit stream.

Top module: `nrzi_line_coder`

## Requirements
- R1: After reset, `line_out` is 0 and `in_ready` is 1. The generator holds its seed of all ones, so the first data nibble after reset uses keystream 0000.
- R2: A data nibble (`in_kind` = 2'b00) is sent as the 5-bit group for (nibble XOR keystream). The table, hex nibble to group, is: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. The group's MSB goes first, one bit per cycle, and the first bit reaches the line on the clock edge after acceptance.
- R3: The generator is a 10-bit register s. Each step computes k = s[9] XOR s[6] and sets s to {s[8:0], k}. A data nibble takes four steps, and the key bit of the first step lands on the nibble's MSB.
- R4: A command symbol (`in_kind` = 2'b01, and 2'b11 behaves the same) sends the escape group (parameter `ESC_CODE`, default 00010) and then the table group of the unscrambled nibble: ten bits, MSB first.
- R5: The reseed command (`in_kind` = 2'b10) sends the escape group twice. The next data nibble uses the keystream that follows the seed.
- R6: Command symbols and the reseed command never advance the generator. A data nibble sent after a command uses the key that follows the last data nibble.
- R7: The line is NRZI coded: a 1 bit toggles `line_out` and a 0 bit holds it. While no bits are pending, `line_out` holds its level.
- R8: `in_ready` is high exactly when at most one bit of the current groups is left to send. A nibble is taken on an edge with `in_valid` and `in_ready` both high. An `in_valid` presented while `in_ready` is low is ignored and leaves the line stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A nibble is offered |
| in_kind | input | 2 | 00 data, 01/11 command symbol, 10 reseed command |
| in_nibble | input | 4 | Nibble value |
| in_ready | output | 1 | The coder can take a nibble on this edge |
| line_out | output | 1 | NRZI-coded line level |

## Verification
A nibble accepted on edge n puts the first bit of its group on `line_out` right after edge n+1. Bit k follows after edge n+k. `in_ready` follows the number of bits still pending, which changes only at an edge. The bench therefore drives inputs and samples outputs 1 ns after each rising edge. Its model queues the expected bits at each acceptance and pops one bit per edge, so every line level is compared against the edge that produced it.

// File: rtl/nrzi_line_coder.sv
module nrzi_line_coder #(
  parameter int         LFSR_W   = 10,
  parameter int         TAP_LO   = 6,
  parameter logic [4:0] ESC_CODE = 5'b00010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_kind,
  input  logic [3:0] in_nibble,
  output logic       in_ready,
  output logic       line_out
);
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam int SH_W  = 2 * GRP_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [LFSR_W-1:0] SEED = '1;

  localparam logic [1:0] K_DATA  = 2'b00;
  localparam logic [1:0] K_RESET = 2'b10;

  function automatic logic [GRP_W-1:0] enc5(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: enc5 = 5'b11110;  4'h1: enc5 = 5'b01001;
      4'h2: enc5 = 5'b10100;  4'h3: enc5 = 5'b10101;
      4'h4: enc5 = 5'b01010;  4'h5: enc5 = 5'b01011;
      4'h6: enc5 = 5'b01110;  4'h7: enc5 = 5'b01111;
      4'h8: enc5 = 5'b10010;  4'h9: enc5 = 5'b10011;
      4'hA: enc5 = 5'b10110;  4'hB: enc5 = 5'b10111;
      4'hC: enc5 = 5'b11010;  4'hD: enc5 = 5'b11011;
      4'hE: enc5 = 5'b11100;  default: enc5 = 5'b11101;
    endcase
  endfunction

  logic [LFSR_W-1:0] lfsr, lfsr_nx;
  logic [NIB_W-1:0]  key;
  logic [SH_W-1:0]   shreg;
  logic [CNT_W-1:0]  rem;
  logic              accept;

  assign in_ready = (rem <= CNT_W'(1));
  assign accept   = in_valid & in_ready;

  always_comb begin
    logic [LFSR_W-1:0] s;
    logic kb;
    s = lfsr;
    key = '0;
    for (int i = 0; i < NIB_W; i++) begin
      kb = s[LFSR_W-1] ^ s[TAP_LO];
      key[NIB_W-1-i] = kb;
      s = {s[LFSR_W-2:0], kb};
    end
    lfsr_nx = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      shreg    <= '0;
      rem      <= '0;
      line_out <= 1'b0;
    end else begin
      if (rem != '0) line_out <= line_out ^ shreg[SH_W-1];
      if (accept) begin
        if (in_kind == K_DATA) begin
          shreg <= {enc5(in_nibble ^ key), {GRP_W{1'b0}}};
          rem   <= CNT_W'(GRP_W);
          lfsr  <= lfsr_nx;
        end else if (in_kind == K_RESET) begin
          shreg <= {ESC_CODE, ESC_CODE};
          rem   <= CNT_W'(SH_W);
          lfsr  <= SEED;
        end else begin
          shreg <= {ESC_CODE, enc5(in_nibble)};
          rem   <= CNT_W'(SH_W);
        end
      end else if (rem != '0) begin
        shreg <= {shreg[SH_W-2:0], 1'b0};
        rem   <= rem - CNT_W'(1);
      end
    end
  end

  p_gen_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_cmd_holds_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind[0]) |=> $stable(lfsr));

  p_reseed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == K_RESET) |=> (lfsr == SEED));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem == '0) |=> $stable(line_out));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (rem == $past(rem) - CNT_W'(1)));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CNT_W'(SH_W));
endmodule

// File: tb/tb_nrzi_line_coder.sv
`timescale 1ns/1ps
module tb_nrzi_line_coder;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic [3:0] in_nibble = 4'h0;
  logic in_ready, line_out;

  nrzi_line_coder dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_kind(in_kind), .in_nibble(in_nibble), .in_ready(in_ready), .line_out(line_out));

  always #2 clk = ~clk;

  localparam logic [4:0] ESC = 5'b00010;
  // stimulus vectors {kind, nibble}; expected groups come from the model below
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    6'h20, 6'h00, 6'h05, 6'h0F, 6'h14, 6'h0A, 6'h13, 6'h08,
    6'h20, 6'h00, 6'h3C, 6'h07, 6'h01, 6'h0E};

  int checks = 0, fails = 0;
  bit done = 0;
  bit q[$];
  string tq[$];
  string cur_tag;
  logic exp_line = 1'b0;
  logic [9:0] mgen = '1;
  bit after_cmd = 0;

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
      5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011,
      5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_grp(input logic [4:0] g, input string tag);
    for (int b = 4; b >= 0; b--) begin q.push_back(g[b]); tq.push_back(tag); end
  endtask

  task automatic model_accept(input logic [1:0] k, input logic [3:0] n);
    logic [3:0] key;
    logic kb;
    if (k == 2'b00) begin
      for (int i = 0; i < 4; i++) begin
        kb = mgen[9] ^ mgen[6];
        key[3-i] = kb;
        mgen = {mgen[8:0], kb};
      end
      push_grp(code(n ^ key), after_cmd ? "R6" : "R2/R3");
      after_cmd = 0;
    end else if (k == 2'b10) begin
      push_grp(ESC, "R5"); push_grp(ESC, "R5");
      mgen = '1;
      after_cmd = 0;
    end else begin
      push_grp(ESC, "R4"); push_grp(code(n), "R4");
      after_cmd = 1;
    end
  endtask

  task automatic tick(input bit acc, input logic [1:0] k, input logic [3:0] n);
    @(posedge clk); #1;
    if (q.size() > 0) begin exp_line ^= q.pop_front(); cur_tag = tq.pop_front(); end
    else cur_tag = "R7";
    if (acc) model_accept(k, n);
    chk(line_out === exp_line, cur_tag, line_out, exp_line);
    chk(in_ready === (q.size() <= 1), "R8", in_ready, q.size() <= 1);
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] n);
    bit acc;
    in_valid = 1; in_kind = k; in_nibble = n;
    do begin
      acc = in_ready;
      tick(acc, k, n);
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic drain(input int extra);
    while (q.size() > 0) tick(0, 2'b00, 4'h0);
    for (int i = 0; i < extra; i++) tick(0, 2'b00, 4'h0);
  endtask

  initial begin
    #801000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #5;
    chk(line_out === 1'b0, "R1", line_out, 0);
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    @(posedge clk); #1; rst_n = 1;
    // R1: first data nibble from seed uses key 0000
    send(2'b00, 4'h0);
    drain(0);
    for (int i = 0; i < NV; i++) send(VEC[i][5:4], VEC[i][3:0]);
    drain(3); // R7: idle line holds
    // R8: offers while busy are ignored
    send(2'b01, 4'h3);
    in_valid = 1; in_kind = 2'b00; in_nibble = 4'h9;
    while (q.size() > 2) tick(0, 2'b00, 4'h0);
    in_valid = 0;
    send(2'b00, 4'h6);
    send(2'b00, 4'hB);
    drain(2);
    // R1: mid-stream reset restores seed and line
    send(2'b00, 4'h2);
    send(2'b00, 4'hD);
    tick(0, 2'b00, 4'h0);
    rst_n = 0; #1;
    q.delete(); tq.delete(); exp_line = 0; mgen = '1; after_cmd = 0;
    chk(line_out === 1'b0, "R1", line_out, 0);
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    @(posedge clk); #1; rst_n = 1;
    send(2'b00, 4'h0);
    send(2'b00, 4'h1);
    send(2'b01, 4'h8);
    send(2'b00, 4'h1);
    drain(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule